// File: doc/BRIEF.md
# Smart card power sequencer

This block powers a contact smart card up and down in a fixed order with timed gaps. The host opens a session by pulling an active-low command input low. The block then enables the card supply and checks, after a settling interval, that the supply is good. It waits for the host reset request to go low and moves the card I/O line into reception mode. After a further gap it starts the card clock. The card reset stays low for a programmed number of card clock pulses. Only then does it follow the host reset request.

A session ends when the command input returns high, or when a hardware fault is seen. The faults are over-current, overheating, a VDD fault, loss of card supply, or card removal. The block then drops the signals in reverse order: card reset, then card clock, then I/O (held low), then supply. Each step waits its own interval. A last discharge wait ends with the supply reported low. A fault drives the active-low fault output low, and it stays low until the command input returns high.

All slow intervals are counted in ticks of an oscillator enable. The reset hold is counted in card clock enable pulses. Both are set by parameters.

Top module: `sc_power_seq`

## Requirements
- R1: When idle, with `fault_n` high, `cmd_n` low sets `supply_en` at the next clock edge, and `supply_low` falls at the same edge.
- R2: `supply_ok` is sampled on the last tick of the `T_CHECK` supply check interval. If it is low then, `fault_n` goes low and deactivation starts.
- R3: `io_rx` rises `T_IO` oscillator ticks after `host_rst` is seen low in the wait step. While `host_rst` stays high, `io_rx` stays low.
- R4: `card_clk_gate` rises `T_CLK` ticks after `io_rx` rises, and never while `io_rx` is low.
- R5: `card_rst` stays low until `RST_HOLD` card clock pulses have been counted after `card_clk_gate` rose, whatever `host_rst` does. After that it equals `host_rst`.
- R6: The reset hold count restarts from zero on every activation, including after an aborted one.
- R7: On deactivation, `card_rst` falls first. `card_clk_gate`, `io_rx` and `supply_en` then fall in that order, each `T_STEP` ticks after the one before.
- R8: `supply_low` rises `T_DISCH` ticks after `supply_en` falls, and is high only while nothing is powered. It is high after reset.
- R9: During a session, any of `flt_overcur`, `flt_hot`, `flt_vdd`, a low `card_present`, or a low `supply_ok` after the check starts deactivation and drives `fault_n` low. `fault_n` returns high only once `cmd_n` is high.
- R10: Changes of `cmd_n` during deactivation have no effect on the outputs. A `cmd_n` held low through a fault does not start a new session.
- R11: Fault flags raised while idle do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable that times the intervals |
| card_clk_en | input | 1 | One-cycle pulse per card clock period |
| cmd_n | input | 1 | Active-low session request from the host |
| host_rst | input | 1 | Host card reset request |
| supply_ok | input | 1 | Card supply is within range |
| flt_overcur | input | 1 | Over-current fault flag |
| flt_hot | input | 1 | Overheat fault flag |
| flt_vdd | input | 1 | Logic supply fault flag |
| card_present | input | 1 | Card is inserted |
| supply_en | output | 1 | Card supply enable |
| card_clk_gate | output | 1 | Card clock gate enable |
| card_rst | output | 1 | Card reset output |
| io_rx | output | 1 | 1: I/O in reception mode, 0: I/O held low |
| supply_low | output | 1 | Card supply has been off for the full discharge interval |
| fault_n | output | 1 | Active-low fault report to the host |

## Verification
A plain session, opened with the host reset already low, shows the forward order and the reset hold. In that session `host_rst` is raised during the hold, which shows the hold overriding the host. A session opened with `host_rst` high shows that the I/O step waits for the reset request to fall. Several abort patterns are applied: a bad supply at the check, card removal while running, a one-cycle over-current pulse during the hold, and supply loss while running. They tell the check-time fault from session faults, and show that shutdown starts from whichever step was reached. Toggling `cmd_n` during shutdown, holding it low through a fault, and raising faults while idle show the cases where requests and flags must be ignored. A behavioural reference model compares every output on every clock.

// File: rtl/sc_seq_pkg.sv
// Package: state encoding shared by the sequencer modules.
// Assumes the forward states are listed in activation order, then the shutdown states.
package sc_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_CHK,
        ST_WAIT_HR,
        ST_IO_DLY,
        ST_CLK_DLY,
        ST_HOLD,
        ST_RUN,
        ST_D_RST,
        ST_D_CLK,
        ST_D_IO,
        ST_D_VCC
    } seq_state_e;
endpackage

// File: rtl/sc_tick_timer.sv
// Interval timer: counts oscillator ticks while run is high and flags the
// tick that completes `limit` ticks. Assumes limit >= 1. It is cleared by
// the owner on every step change.
module sc_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Tick counter, restarted on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (run && tick) cnt_q <= cnt_q + W'(1);
    end

    // Completion flag on the last tick of the interval.
    assign done = run && tick && (cnt_q == limit - W'(1));

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit)); // R7
endmodule

// File: rtl/sc_hold_counter.sv
// Reset hold counter: counts card clock pulses while enabled and flags the
// pulse that completes HOLD pulses. It returns to zero whenever it is disabled,
// so each activation starts a fresh count.
module sc_hold_counter #(
    parameter int HOLD = 42000,
    localparam int W = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pulse,
    output logic done
);
    logic [W-1:0] cnt_q;

    assign done = en && pulse && (cnt_q == W'(HOLD - 1));

    // Pulse counter, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (pulse && !done) cnt_q <= cnt_q + W'(1);
    end

    AST_HOLD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(HOLD)); // R5
    AST_HOLD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/sc_fault_latch.sv
// Fault collector: merges the hardware flags into one event during a session
// and holds the active-low report until the host withdraws its request.
module sc_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic session,
    input  logic watch_supply,
    input  logic chk_fail,
    input  logic supply_ok,
    input  logic flt_overcur,
    input  logic flt_hot,
    input  logic flt_vdd,
    input  logic card_present,
    input  logic cmd_n,
    output logic fault_evt,
    output logic fault_n
);
    // Fault event: any flag inside a session, or a failed supply check.
    assign fault_evt = (session && (flt_overcur || flt_hot || flt_vdd || !card_present
                        || (watch_supply && !supply_ok))) || chk_fail;

    // Sticky report, released once cmd_n is high.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n <= 1'b1;
        else if (fault_evt) fault_n <= 1'b0;
        else if (cmd_n) fault_n <= 1'b1;
    end

    AST_FAULT_CLEAR_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n && !fault_evt) |=> fault_n); // R9
endmodule

// File: rtl/sc_power_seq.sv
// Smart card power sequencer top: steps the card supply, I/O mode, clock and
// reset through a fixed activation order and the reverse shutdown order.
// Assumes osc_tick and card_clk_en are single-cycle enables in the clk domain
// and every interval parameter is at least 1.
module sc_power_seq
    import sc_seq_pkg::*;
#(
    parameter int T_CHECK  = 765,
    parameter int T_IO     = 3,
    parameter int T_CLK    = 1,
    parameter int T_STEP   = 1,
    parameter int T_DISCH  = 150,
    parameter int RST_HOLD = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic card_clk_en,
    input  logic cmd_n,
    input  logic host_rst,
    input  logic supply_ok,
    input  logic flt_overcur,
    input  logic flt_hot,
    input  logic flt_vdd,
    input  logic card_present,
    output logic supply_en,
    output logic card_clk_gate,
    output logic card_rst,
    output logic io_rx,
    output logic supply_low,
    output logic fault_n
);
    localparam int M_A  = (T_CHECK > T_DISCH) ? T_CHECK : T_DISCH;
    localparam int M_B  = (T_IO > T_CLK) ? T_IO : T_CLK;
    localparam int M_C  = (M_A > M_B) ? M_A : M_B;
    localparam int TMAX = (M_C > T_STEP) ? M_C : T_STEP;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e    state_q, state_d;
    logic          sup_q, clk_q, io_q;
    logic          session, watch, timed, t_done, hold_done;
    logic          chk_fail, fault_evt;
    logic [TW-1:0] limit;

    assign session = (state_q >= ST_PWR_CHK) && (state_q <= ST_RUN);
    assign watch   = (state_q >= ST_WAIT_HR) && (state_q <= ST_RUN);

    // Interval length of the current step.
    always_comb begin
        timed = 1'b1;
        case (state_q)
            ST_PWR_CHK: limit = TW'(T_CHECK);
            ST_IO_DLY:  limit = TW'(T_IO);
            ST_CLK_DLY: limit = TW'(T_CLK);
            ST_D_RST, ST_D_CLK, ST_D_IO: limit = TW'(T_STEP);
            ST_D_VCC:   limit = TW'(T_DISCH);
            default: begin
                limit = TW'(1);
                timed = 1'b0;
            end
        endcase
    end

    sc_tick_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(state_d != state_q), .run(timed),
        .tick(osc_tick), .limit(limit), .done(t_done)
    );

    sc_hold_counter #(.HOLD(RST_HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(state_q == ST_HOLD),
        .pulse(card_clk_en), .done(hold_done)
    );

    assign chk_fail = (state_q == ST_PWR_CHK) && t_done && !supply_ok;

    sc_fault_latch u_fault (
        .clk(clk), .rst_n(rst_n), .session(session), .watch_supply(watch),
        .chk_fail(chk_fail), .supply_ok(supply_ok), .flt_overcur(flt_overcur),
        .flt_hot(flt_hot), .flt_vdd(flt_vdd), .card_present(card_present),
        .cmd_n(cmd_n), .fault_evt(fault_evt), .fault_n(fault_n)
    );

    // Next step: forward progress, with abort to shutdown taking priority.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (!cmd_n && fault_n) state_d = ST_PWR_CHK;
            ST_PWR_CHK: if (t_done) state_d = ST_WAIT_HR;
            ST_WAIT_HR: if (!host_rst) state_d = ST_IO_DLY;
            ST_IO_DLY:  if (t_done) state_d = ST_CLK_DLY;
            ST_CLK_DLY: if (t_done) state_d = ST_HOLD;
            ST_HOLD:    if (hold_done) state_d = ST_RUN;
            ST_D_RST:   if (t_done) state_d = ST_D_CLK;
            ST_D_CLK:   if (t_done) state_d = ST_D_IO;
            ST_D_IO:    if (t_done) state_d = ST_D_VCC;
            ST_D_VCC:   if (t_done) state_d = ST_IDLE;
            default:    state_d = state_q;
        endcase
        if (session && (fault_evt || cmd_n)) state_d = ST_D_RST;
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    // Card control flags, switched only on the step transitions that own them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q <= 1'b0;
            clk_q <= 1'b0;
            io_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_PWR_CHK) sup_q <= 1'b1;
            if (state_q == ST_IO_DLY && state_d == ST_CLK_DLY) io_q <= 1'b1;
            if (state_q == ST_CLK_DLY && state_d == ST_HOLD) clk_q <= 1'b1;
            if (state_q == ST_D_RST && state_d == ST_D_CLK) clk_q <= 1'b0;
            if (state_q == ST_D_CLK && state_d == ST_D_IO) io_q <= 1'b0;
            if (state_q == ST_D_IO && state_d == ST_D_VCC) sup_q <= 1'b0;
        end
    end

    assign supply_en     = sup_q;
    assign card_clk_gate = clk_q;
    assign io_rx         = io_q;
    assign card_rst      = (state_q == ST_RUN) && host_rst;
    assign supply_low    = (state_q == ST_IDLE);

    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (card_clk_gate && io_rx && supply_en)); // R5
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_gate |-> io_rx); // R4
    AST_IO_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        io_rx |-> supply_en); // R3
    AST_LOW_ONLY_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !(supply_en || io_rx || card_clk_gate)); // R8
    AST_FAULT_STARTS_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (session && fault_evt) |=> (state_q == ST_D_RST && !fault_n)); // R9
    AST_SHUTDOWN_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q >= ST_D_RST) |=> (state_q >= ST_D_RST || state_q == ST_IDLE)); // R10
endmodule

// File: tb/sc_power_seq_bench.sv
module sc_power_seq_bench;
    localparam int CLK_P    = 10;
    localparam int T_CHECK  = 4;
    localparam int T_IO     = 2;
    localparam int T_CLK    = 1;
    localparam int T_STEP   = 2;
    localparam int T_DISCH  = 3;
    localparam int RST_HOLD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0, card_clk_en = 1'b0;
    logic cmd_n = 1'b1, host_rst = 1'b0, supply_ok = 1'b1;
    logic flt_overcur = 1'b0, flt_hot = 1'b0, flt_vdd = 1'b0, card_present = 1'b1;
    logic supply_en, card_clk_gate, card_rst, io_rx, supply_low, fault_n;

    int n_checks = 0, n_errors = 0, cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    sc_power_seq #(.T_CHECK(T_CHECK), .T_IO(T_IO), .T_CLK(T_CLK), .T_STEP(T_STEP),
                   .T_DISCH(T_DISCH), .RST_HOLD(RST_HOLD)) u_sc_power_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .card_clk_en(card_clk_en),
        .cmd_n(cmd_n), .host_rst(host_rst), .supply_ok(supply_ok),
        .flt_overcur(flt_overcur), .flt_hot(flt_hot), .flt_vdd(flt_vdd),
        .card_present(card_present), .supply_en(supply_en), .card_clk_gate(card_clk_gate),
        .card_rst(card_rst), .io_rx(io_rx), .supply_low(supply_low), .fault_n(fault_n)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", what, cyc, act, exp);
        end
    endtask

    // Reference model: phase number plus elapsed counts, updated behaviourally.
    int ph = 0, tk = 0, pc = 0, nph = 0, need = 0;
    bit m_sup = 0, m_clk = 0, m_io = 0, m_fn = 1, inses = 0, tfin = 0, fev = 0;

    function automatic int span(input int p);
        case (p)
            1: return T_CHECK;
            3: return T_IO;
            4: return T_CLK;
            7, 8, 9: return T_STEP;
            10: return T_DISCH;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; tk = 0; pc = 0; m_sup = 0; m_clk = 0; m_io = 0; m_fn = 1;
        end else begin
            inses = (ph >= 1 && ph <= 6);
            need  = span(ph);
            tfin  = (need > 0) && osc_tick && (tk == need - 1);
            fev   = inses && (flt_overcur || flt_hot || flt_vdd || !card_present
                     || (ph >= 2 && !supply_ok) || (ph == 1 && tfin && !supply_ok));
            nph = ph;
            if (ph == 0 && !cmd_n && m_fn) nph = 1;
            else if (ph == 2 && !host_rst) nph = 3;
            else if (ph == 5 && card_clk_en && pc == RST_HOLD - 1) nph = 6;
            else if (tfin) nph = (ph == 10) ? 0 : ph + 1;
            if (inses && (fev || cmd_n)) nph = 7;
            if (fev) m_fn = 0;
            else if (cmd_n) m_fn = 1;
            if (ph == 0 && nph == 1) m_sup = 1;
            if (ph == 3 && nph == 4) m_io = 1;
            if (ph == 4 && nph == 5) m_clk = 1;
            if (ph == 7 && nph == 8) m_clk = 0;
            if (ph == 8 && nph == 9) m_io = 0;
            if (ph == 9 && nph == 10) m_sup = 0;
            if (nph != ph) tk = 0;
            else if (need > 0 && osc_tick) tk++;
            if (ph != 5) pc = 0;
            else if (card_clk_en && pc != RST_HOLD - 1) pc++;
            ph = nph;
        end
    end

    // Observed shutdown edges and reset-hold pulse count, taken at the compare point.
    int t_rst = 0, t_clk = 0, t_io = 0, t_sup = 0, hold_pulses = 0;
    bit p_rst = 0, p_clk = 0, p_io = 0, p_sup = 0, first_rst = 1, order_seen = 0;

    // Per-cycle comparison a quarter period after each edge, plus watchdog.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            cyc++;
            if (rst_n) begin
                check(supply_en, m_sup, "R1/R2 supply_en vs model");
                check(io_rx, m_io, "R3 io_rx vs model");
                check(card_clk_gate, m_clk, "R4 card_clk_gate vs model");
                check(card_rst, (ph == 6) && host_rst, "R5 card_rst vs model");
                check(supply_low, ph == 0, "R8 supply_low vs model");
                check(fault_n, m_fn, "R9 fault_n vs model");
                if (p_rst && !card_rst) t_rst = cyc;
                if (p_clk && !card_clk_gate) t_clk = cyc;
                if (p_io && !io_rx) t_io = cyc;
                if (p_sup && !supply_en) begin t_sup = cyc; order_seen = 1; end
                if (!p_clk) begin hold_pulses = 0; first_rst = 1; end
                else if (!p_rst && card_clk_en) hold_pulses++;
                if (!p_rst && card_rst && first_rst && host_rst) begin
                    check(hold_pulses == RST_HOLD, 1'b1, "R6 hold pulses before reset release");
                    first_rst = 0;
                end
            end
            p_rst = card_rst; p_clk = card_clk_gate; p_io = io_rx; p_sup = supply_en;
            if (cyc > 150000) begin
                n_errors++; n_checks++;
                $display("FAIL watchdog expired: actual=running expected=finished");
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    // Periodic oscillator tick (1 in 3) and card clock pulse (1 in 2).
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            osc_tick = (k % 3 == 0);
            card_clk_en = (k % 2 == 0);
            k++;
        end
    end

    task automatic wait_ph(input int p);
        for (int i = 0; i < 3000; i++) begin
            if (ph == p) return;
            @(posedge clk);
            #(CLK_P/4);
        end
        n_checks++; n_errors++;
        $display("FAIL wait for phase %0d: actual=%0d expected=%0d", p, ph, p);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_order(input string tag);
        check(order_seen && t_rst > 0 && t_rst < t_clk && t_clk < t_io && t_io < t_sup,
              1'b1, tag);
        order_seen = 0;
    endtask

    initial begin
        idle_cycles(4);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_P/4);
        check(supply_en, 1'b0, "R1 reset supply_en");
        check(supply_low, 1'b1, "R8 reset supply_low");
        check(fault_n, 1'b1, "R9 reset fault_n");

        // Faults while idle change nothing.
        @(negedge clk); flt_hot = 1'b1; card_present = 1'b0;
        idle_cycles(6);
        check(fault_n, 1'b1, "R11 idle fault_n");
        check(supply_en, 1'b0, "R11 idle supply_en");
        @(negedge clk); flt_hot = 1'b0; card_present = 1'b1;

        // Plain session, host reset raised during the hold.
        @(negedge clk); host_rst = 1'b0; cmd_n = 1'b0;
        @(posedge clk); #(CLK_P/4);
        check(supply_en, 1'b1, "R1 supply on after request");
        wait_ph(5);
        @(negedge clk); host_rst = 1'b1;
        idle_cycles(3);
        check(card_rst, 1'b0, "R5 reset held during hold");
        wait_ph(6);
        @(negedge clk);
        check(card_rst, 1'b1, "R5 reset follows host after hold");
        host_rst = 1'b0; idle_cycles(3); host_rst = 1'b1; idle_cycles(3);
        cmd_n = 1'b1;
        wait_ph(0);
        check_order("R7 shutdown order after host release");

        // Host reset high at request: I/O waits; then card removal while running.
        @(negedge clk); host_rst = 1'b1; cmd_n = 1'b0;
        wait_ph(2);
        idle_cycles(15);
        check(io_rx, 1'b0, "R3 I/O waits for host reset low");
        host_rst = 1'b0;
        wait_ph(6);
        @(negedge clk); card_present = 1'b0;
        @(negedge clk);
        check(fault_n, 1'b0, "R9 card removal fault");
        wait_ph(0);
        check_order("R7 shutdown order after removal");
        @(negedge clk); card_present = 1'b1;
        idle_cycles(20);
        check(supply_en, 1'b0, "R10 no restart while fault latched");
        check(fault_n, 1'b0, "R9 fault held with cmd_n low");
        cmd_n = 1'b1;
        @(negedge clk);
        check(fault_n, 1'b1, "R9 fault released by cmd_n high");

        // Bad supply at the check.
        @(negedge clk); supply_ok = 1'b0; cmd_n = 1'b0;
        wait_ph(7);
        @(negedge clk);
        check(fault_n, 1'b0, "R2 supply check fault");
        supply_ok = 1'b1;
        wait_ph(0);
        @(negedge clk); cmd_n = 1'b1;
        idle_cycles(2);

        // Over-current pulse during the hold; cmd_n toggled during shutdown.
        @(negedge clk); host_rst = 1'b0; cmd_n = 1'b0;
        wait_ph(5);
        idle_cycles(4);
        flt_overcur = 1'b1;
        @(negedge clk); flt_overcur = 1'b0;
        check(card_clk_gate, 1'b1, "R7 clock still on at shutdown start");
        cmd_n = 1'b1; idle_cycles(2); cmd_n = 1'b0; idle_cycles(2); cmd_n = 1'b1;
        idle_cycles(2); cmd_n = 1'b0;
        check(supply_low, 1'b0, "R10 shutdown continues under cmd_n toggles");
        wait_ph(0);
        check_order("R7 shutdown order after over-current");
        // cmd_n still low and fault released: fresh activation with a fresh hold.
        wait_ph(5);
        @(negedge clk); host_rst = 1'b1;
        wait_ph(6);
        @(negedge clk);
        check(card_rst, 1'b1, "R6 second hold completes");

        // Supply lost while running.
        supply_ok = 1'b0;
        @(negedge clk);
        check(fault_n, 1'b0, "R9 supply loss fault");
        supply_ok = 1'b1;
        wait_ph(10);
        idle_cycles(2);
        check(supply_low, 1'b0, "R8 discharge wait before supply_low");
        wait_ph(0);
        @(negedge clk);
        check(supply_low, 1'b1, "R8 supply_low after discharge");
        cmd_n = 1'b1;
        idle_cycles(4);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule